// File: doc/BRIEF.md
# SPI Serial Clock Rate Selector

The block turns a requested serial bit rate into a two-stage clock divider setting and then produces the serial clock from it. The divider chain runs in two steps. A prescaler divides the main clock by `2 << div_sel`. The result is then divided by `2 * (brg_val + 1)`. A controller supplies the main clock frequency and the wanted rate, both in hertz, and pulses `start`. When `done` rises, the chosen prescaler exponent and baud count are on the outputs. They stay there until the next `start`.

The selection first forms a single quotient: the main frequency divided by the rate, by bit-serial long division. It then tries the prescaler exponents from the smallest upward. The first exponent whose scaled quotient fits the baud counter wins. A request faster than the chain can reach is clamped to the fastest legal setting. A request slower than the chain can reach is clamped to the slowest one. While `sck_en` is high, the clock generator toggles `sck` at the selected rate and marks each edge with a one-cycle `sck_tick`. While `sck_en` is low, `sck` rests at the idle level given by `sck_idle`.

Top module: `spi_baud_select`

## Requirements
- R1: After reset, `div_sel` is 0, `brg_val` is 4, and `done`, `sck` and `sck_tick` are 0.
- R2: Whenever `done` is high, `div_sel` lies in 0..3 and `brg_val` lies in 4..63.
- R3: For a nonzero rate, let Q = floor(floor(main/rate) / (4 << d)). The block takes the smallest d in 0..3 for which 5 <= Q <= 64, and reports `div_sel` = d and `brg_val` = Q - 1.
- R4: If Q at d = 0 is below 5 (the request is too fast), the result is `div_sel` = 0 and `brg_val` = 4.
- R5: If no d in 0..3 gives Q <= 64 (the request is too slow), the result is `div_sel` = 3 and `brg_val` = 63.
- R6: A rate of zero gives `div_sel` = 3 and `brg_val` = 63 without any division. `done` is high in the cycle right after the start edge.
- R7: A start edge with a nonzero rate clears `done`. `done` rises FW+1 clock edges after the start edge.
- R8: While `sck_en` is high, `sck` toggles every (brg_val+1) << (div_sel+1) main-clock cycles. `sck_tick` is high for exactly the one cycle that follows each toggle.
- R9: While `sck_en` is low, `sck` equals `sck_idle` from the next cycle on, and `sck_tick` stays 0.
- R10: At the edges of the reachable range the result follows the same search. For main/20 the result is `div_sel` = 0 and `brg_val` = 4. Rates just above main/2049 still fit at `div_sel` = 3. A somewhat lower rate clamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to compute a new setting |
| main_hz | input | FW | Main clock frequency in hertz |
| rate_hz | input | FW | Requested serial rate in hertz |
| sck_en | input | 1 | Enables serial clock generation |
| sck_idle | input | 1 | Idle level of `sck` while disabled |
| div_sel | output | DW | Selected prescaler exponent |
| brg_val | output | BW | Selected baud count |
| done | output | 1 | Setting valid |
| sck | output | 1 | Generated serial clock |
| sck_tick | output | 1 | One-cycle pulse after each `sck` toggle |

## Verification
The bench builds the block with FW=24, DW=2 and BW=6. A 24-bit frequency field lets main clocks of several megahertz and rates of a few hertz be requested. This exercises both clamps, every prescaler exponent and the exact FW+1 edge latency of the long division. With a 6-bit baud count and four exponents, the longest half-period is 1024 cycles. The bench can therefore time several `sck` edges at the slowest setting as well as at the fastest.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

  // Outcome of the prescaler search
  typedef enum logic [1:0] {
    V_FIT  = 2'd0,
    V_FAST = 2'd1,
    V_SLOW = 2'd2
  } baud_verdict_t;

  // Right shift that turns floor(main/rate) into BRG+1 for exponent d:
  // dividing by (4 << d) is a shift by d + 2.
  function automatic int prescale_shift(input int d);
    return d + 2;
  endfunction

  // Main-clock cycles between two serial clock toggles.
  function automatic int half_period(input int brg, input int div);
    return (brg + 1) << (div + 1);
  endfunction

endpackage

// File: rtl/spi_baud_divu.sv
module spi_baud_divu #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [FW-1:0] num,
  input  logic [FW-1:0] den,
  output logic          busy,
  output logic          q_valid,
  output logic [FW-1:0] quot
);
  localparam int SW = $clog2(FW + 1);

  logic [FW-1:0] rem_q, quo_q, den_q, num_q;
  logic [SW-1:0] step_q;
  logic [FW:0]   shifted, diff;
  logic          ge;

  assign shifted = {rem_q, quo_q[FW-1]};
  assign ge      = shifted >= {1'b0, den_q};
  assign diff    = shifted - {1'b0, den_q};
  assign quot    = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      quo_q   <= '0;
      den_q   <= '0;
      num_q   <= '0;
      step_q  <= '0;
      busy    <= 1'b0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= 1'b0;
      if (go) begin
        rem_q  <= '0;
        quo_q  <= num;
        num_q  <= num;
        den_q  <= den;
        step_q <= SW'(FW);
        busy   <= (den != '0);
      end else if (busy) begin
        rem_q  <= ge ? diff[FW-1:0] : shifted[FW-1:0];
        quo_q  <= {quo_q[FW-2:0], ge};
        step_q <= step_q - SW'(1);
        if (step_q == SW'(1)) begin
          busy    <= 1'b0;
          q_valid <= 1'b1;
        end
      end
    end
  end

  // R3: the finished quotient and remainder reconstruct the dividend exactly
  p_quotient_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> ((2*FW)'(quo_q) * (2*FW)'(den_q) + (2*FW)'(rem_q) == (2*FW)'(num_q))
                && (rem_q < den_q));

endmodule

// File: rtl/spi_baud_search.sv
module spi_baud_search
  import spi_baud_pkg::*;
#(
  parameter int FW      = 32,
  parameter int DW      = 2,
  parameter int BW      = 6,
  parameter int BRG_MIN = 4
) (
  input  logic [FW-1:0]  base,
  output logic [DW-1:0]  div_o,
  output logic [BW-1:0]  brg_o,
  output baud_verdict_t  verdict_o
);
  localparam int NDIV    = 1 << DW;
  localparam int BRG_MAX = (1 << BW) - 1;
  localparam logic [FW-1:0] LIM_LO = FW'(BRG_MIN + 1);
  localparam logic [FW-1:0] LIM_HI = FW'(BRG_MAX + 1);

  logic [FW-1:0] q [NDIV];
  logic          hit;

  // One scaled quotient per prescaler exponent
  generate
    for (genvar g = 0; g < NDIV; g++) begin : g_pre
      assign q[g] = base >> prescale_shift(g);
    end
  endgenerate

  // Ascending search: first exponent that is too fast or fits decides
  always_comb begin
    hit       = 1'b0;
    verdict_o = V_SLOW;
    div_o     = DW'(NDIV - 1);
    brg_o     = BW'(BRG_MAX);
    for (int d = 0; d < NDIV; d++) begin
      if (!hit) begin
        if (q[d] < LIM_LO) begin
          hit       = 1'b1;
          verdict_o = V_FAST;
          div_o     = DW'(d);
          brg_o     = BW'(BRG_MIN);
        end else if (q[d] <= LIM_HI) begin
          hit       = 1'b1;
          verdict_o = V_FIT;
          div_o     = DW'(d);
          brg_o     = BW'(q[d] - FW'(1));
        end
      end
    end
  end

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_baud_pkg::*;
#(
  parameter int DW = 2,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div_i,
  input  logic [BW-1:0] brg_i,
  input  logic          en_i,
  input  logic          idle_i,
  output logic          sck_o,
  output logic          tick_o
);
  localparam int NDIV = 1 << DW;
  localparam int CW   = BW + NDIV + 1;

  logic [CW-1:0] cnt_q, period;

  assign period = CW'(half_period(int'(brg_i), int'(div_i)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sck_o  <= 1'b0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sck_o  <= idle_i;
      tick_o <= 1'b0;
    end else if (cnt_q >= period - CW'(1)) begin
      cnt_q  <= '0;
      sck_o  <= ~sck_o;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
      tick_o <= 1'b0;
    end
  end

  // R9: disabled generator rests at the idle level with no tick
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (sck_o == $past(idle_i)) && !tick_o);

  // R8: the clock changes exactly when a tick is raised
  p_toggle_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> ((sck_o != $past(sck_o)) == tick_o));

  // R8: a tick lasts a single cycle
  p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/spi_baud_select.sv
module spi_baud_select
  import spi_baud_pkg::*;
#(
  parameter int FW      = 32,
  parameter int DW      = 2,
  parameter int BW      = 6,
  parameter int BRG_MIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] main_hz,
  input  logic [FW-1:0] rate_hz,
  input  logic          sck_en,
  input  logic          sck_idle,
  output logic [DW-1:0] div_sel,
  output logic [BW-1:0] brg_val,
  output logic          done,
  output logic          sck,
  output logic          sck_tick
);
  localparam int NDIV    = 1 << DW;
  localparam int BRG_MAX = (1 << BW) - 1;

  logic          rate_zero;
  logic          div_busy, q_valid;
  logic [FW-1:0] base;
  logic [DW-1:0] s_div;
  logic [BW-1:0] s_brg;
  baud_verdict_t verdict;

  assign rate_zero = (rate_hz == '0);

  spi_baud_divu #(.FW(FW)) u_divu (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (start),
    .num     (main_hz),
    .den     (rate_hz),
    .busy    (div_busy),
    .q_valid (q_valid),
    .quot    (base)
  );

  spi_baud_search #(.FW(FW), .DW(DW), .BW(BW), .BRG_MIN(BRG_MIN)) u_search (
    .base      (base),
    .div_o     (s_div),
    .brg_o     (s_brg),
    .verdict_o (verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel <= '0;
      brg_val <= BW'(BRG_MIN);
      done    <= 1'b0;
    end else if (start) begin
      done <= rate_zero;
      if (rate_zero) begin
        div_sel <= DW'(NDIV - 1);
        brg_val <= BW'(BRG_MAX);
      end
    end else if (q_valid) begin
      div_sel <= s_div;
      brg_val <= s_brg;
      done    <= 1'b1;
    end
  end

  spi_sck_gen #(.DW(DW), .BW(BW)) u_sck (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (div_sel),
    .brg_i  (brg_val),
    .en_i   (sck_en),
    .idle_i (sck_idle),
    .sck_o  (sck),
    .tick_o (sck_tick)
  );

  // R2: a published setting never uses a baud count below the floor
  p_legal_brg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(brg_val) >= BRG_MIN));

  // R6: zero rate is answered at once with the slowest setting
  p_zero_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rate_zero) |=> done && (div_sel == DW'(NDIV - 1)) && (brg_val == BW'(BRG_MAX)));

  // R7: a new nonzero request withdraws the old result
  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rate_zero) |=> !done && div_busy);

  // R4: too-fast verdict lands on the fastest legal setting
  p_fast_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !start && verdict == V_FAST) |=> (div_sel == '0) && (brg_val == BW'(BRG_MIN)));

  // R5: too-slow verdict lands on the slowest legal setting
  p_slow_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !start && verdict == V_SLOW) |=> (div_sel == DW'(NDIV - 1)) && (brg_val == BW'(BRG_MAX)));

endmodule

// File: tb/test_spi_baud_select.sv
`timescale 1ns/1ps
module test_spi_baud_select;
  localparam int FW = 24;
  localparam int DW = 2;
  localparam int BW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] main_hz = '0;
  logic [FW-1:0] rate_hz = '0;
  logic          sck_en = 1'b0;
  logic          sck_idle = 1'b0;
  logic [DW-1:0] div_sel;
  logic [BW-1:0] brg_val;
  logic          done;
  logic          sck;
  logic          sck_tick;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_baud_select #(.FW(FW), .DW(DW), .BW(BW)) i_spi_baud_select (
    .clk(clk), .rst_n(rst_n), .start(start), .main_hz(main_hz), .rate_hz(rate_hz),
    .sck_en(sck_en), .sck_idle(sck_idle), .div_sel(div_sel), .brg_val(brg_val),
    .done(done), .sck(sck), .sck_tick(sck_tick)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent model: nested truncating divisions, ascending exponent
  task automatic model(input int unsigned m, input int unsigned r, output int d, output int b);
    d = 3; b = 63;
    if (r == 0) return;
    for (int k = 0; k < 4; k++) begin
      int unsigned q;
      q = m / r / (4 << k);
      if (q < 5) begin d = k; b = 4; return; end
      if (q <= 64) begin d = k; b = int'(q) - 1; return; end
    end
  endtask

  // Issue one request and check latency and result
  task automatic run_cfg(input int unsigned m, input int unsigned r, input string req);
    int ed, eb, k;
    model(m, r, ed, eb);
    @(negedge clk);
    main_hz = FW'(m); rate_hz = FW'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    if (r == 0) begin
      chk(done == 1'b1, "R6", "done right after start", int'(done), 1);
    end else begin
      chk(done == 1'b0, "R7", "done cleared by start", int'(done), 0);
      while (!done && k < 200) begin @(negedge clk); k++; end
      chk(k == FW + 1, "R7", "latency in edges", k, FW + 1);
    end
    chk(int'(div_sel) == ed, req, "div_sel", int'(div_sel), ed);
    chk(int'(brg_val) == eb, req, "brg_val", int'(brg_val), eb);
    chk(brg_val >= 4 && div_sel <= 3, "R2", "legal range brg", int'(brg_val), 4);
  endtask

  task automatic t_reset();
    chk(div_sel == '0, "R1", "reset div_sel", int'(div_sel), 0);
    chk(brg_val == BW'(4), "R1", "reset brg_val", int'(brg_val), 4);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    chk(sck == 1'b0, "R1", "reset sck", int'(sck), 0);
    chk(sck_tick == 1'b0, "R1", "reset tick", int'(sck_tick), 0);
  endtask

  task automatic t_search_fit();
    run_cfg(1000, 50, "R3");
    run_cfg(100000, 250, "R3");
    chk(div_sel == 2'd1 && brg_val == 6'd49, "R3", "div1 case brg", int'(brg_val), 49);
    run_cfg(1000000, 1000, "R3");
    run_cfg(1000000, 500, "R3");
    run_cfg(3000000, 7000, "R3");
  endtask

  task automatic t_fast();
    run_cfg(1000000, 60000, "R4");
    chk(div_sel == 2'd0 && brg_val == 6'd4, "R4", "fast clamp brg", int'(brg_val), 4);
    run_cfg(1000, 1000, "R4");
    run_cfg(1000, 5000, "R4");
  endtask

  task automatic t_slow();
    run_cfg(1000000, 100, "R5");
    chk(div_sel == 2'd3 && brg_val == 6'd63, "R5", "slow clamp brg", int'(brg_val), 63);
    run_cfg(16000000, 1, "R5");
  endtask

  task automatic t_zero();
    run_cfg(1000000, 2000, "R3");
    run_cfg(1000000, 0, "R6");
    chk(div_sel == 2'd3 && brg_val == 6'd63, "R6", "zero rate brg", int'(brg_val), 63);
  endtask

  task automatic t_bounds();
    run_cfg(1000000, 50000, "R10");
    chk(div_sel == 2'd0 && brg_val == 6'd4, "R10", "top rate brg", int'(brg_val), 4);
    run_cfg(1000000, 489, "R10");
    chk(div_sel == 2'd3, "R10", "near floor div", int'(div_sel), 3);
    run_cfg(1000000, 480, "R10");
  endtask

  // Time the serial clock at the current setting
  task automatic t_sck(input int unsigned m, input int unsigned r, input bit idle);
    int ed, eb, n, w;
    bit prev;
    run_cfg(m, r, "R3");
    model(m, r, ed, eb);
    n = (eb + 1) << (ed + 1);
    @(negedge clk);
    sck_idle = idle; sck_en = 1'b1;
    w = 0;
    while (!sck_tick && w < 5000) begin @(negedge clk); w++; end
    chk(sck_tick == 1'b1, "R8", "first tick seen", int'(sck_tick), 1);
    prev = sck;
    for (int rep = 0; rep < 3; rep++) begin
      int c;
      c = 0;
      do begin @(negedge clk); c++; end while (!sck_tick && c < 5000);
      chk(c == n, "R8", "cycles between toggles", c, n);
      chk(sck != prev, "R8", "sck toggled at tick", int'(sck), int'(!prev));
      prev = sck;
    end
    sck_en = 1'b0;
  endtask

  task automatic t_idle(input bit idle);
    int ticks;
    @(negedge clk);
    sck_idle = idle; sck_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(sck == idle, "R9", "idle level", int'(sck), int'(idle));
    ticks = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sck_tick) ticks++;
      if (sck != idle) ticks++;
    end
    chk(ticks == 0, "R9", "activity while disabled", ticks, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_search_fit();
    t_fast();
    t_slow();
    t_zero();
    t_bounds();
    t_sck(1000, 50, 1'b0);
    t_sck(100000, 250, 1'b1);
    t_sck(1000000, 100, 1'b0);
    t_idle(1'b1);
    t_idle(1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule